// File: doc/BRIEF.md
# 4:2 Compressor Tree Multiplier

This block is a purely combinational unsigned multiplier. It takes two W-bit operands, W being 8 by default, and returns their full 2W-bit product. All W×W partial-product bits are formed at once as AND terms, one row per multiplier bit, each row shifted by its bit weight.

The rows are reduced in levels. Every level takes groups of four rows and passes each group through one row of 4:2 counters, which gives two rows. A lateral carry links each counter to its higher-weight neighbour. For W = 8 this means two counter rows at the first level (8 rows to 4) and one counter row at the second level (4 rows to 2). A parallel-prefix carry-propagate adder then adds the last two rows. W = 4 takes a single level.

There is no clock, no state and no handshake. The product follows the operands after the combinational delay only. W must be a power of two and at least 4.

Top module: `tree_mult`

## Requirements
- R1: For W = 8, `prod` equals the unsigned product `op_a * op_b` for every one of the 65,536 operand pairs.
- R2: When either operand is zero, `prod` is zero.
- R3: When `op_b` is 1, `prod` equals `op_a` zero-extended. When `op_a` is 1, `prod` equals `op_b` zero-extended.
- R4: With both operands at their all-ones value, `prod` uses the top bit: 255 × 255 gives 16'hFE01.
- R5: When `op_b` is 2^k, `prod` equals `op_a` shifted left by k places.
- R6: Bit 0 of `prod` equals the AND of bit 0 of `op_a` and bit 0 of `op_b`.
- R7: The block is combinational. A new operand pair gives its product within the same clock period, with no register on the path.
- R8: With W = 4, the same structure yields the 8-bit product of all 256 operand pairs, including 15 × 15 = 225.
- R9: Swapping the operands leaves `prod` unchanged.
- R10: The 4:2 counter cell satisfies `sum + 2*(carry + cout) = x0 + x1 + x2 + x3 + cin`. Its `cout` does not depend on `cin`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | W | Multiplicand, unsigned |
| op_b | input | W | Multiplier, unsigned; bit i selects partial-product row i |
| prod | output | 2W | Unsigned product |

## Verification
Every result of this block is due in the same cycle as its stimulus, with zero register stages. The bench applies an operand pair just after a rising edge and reads `prod` at the following falling edge. That leaves half a period for the logic to settle and keeps every read away from the edge where inputs change. The standalone counter cell is checked the same way: inputs are driven after the rising edge and outputs are read at the falling edge.

// File: rtl/tree_mult_pkg.sv
package tree_mult_pkg;

    // Number of partial-product rows present at reduction level lvl.
    function automatic int rows_at(input int w, input int lvl);
        return w >> lvl;
    endfunction

    // Number of 4:2 counter rows needed to go from level lvl to lvl+1.
    function automatic int groups_at(input int w, input int lvl);
        return (w >> lvl) / 4;
    endfunction

endpackage

// File: rtl/cnt42.sv
// One 4:2 counter: two cascaded 3:2 cells. The lateral output lat_o is
// formed only from x0..x2, so it never waits on lat_i.
module cnt42 (
    input  logic x0,
    input  logic x1,
    input  logic x2,
    input  logic x3,
    input  logic lat_i,
    output logic sum_o,
    output logic carry_o,
    output logic lat_o
);
    logic mid;

    // first 3:2 stage
    assign mid   = x0 ^ x1 ^ x2;
    assign lat_o = (x0 & x1) | (x0 & x2) | (x1 & x2);

    // second 3:2 stage, absorbs the neighbour's lateral carry
    assign sum_o   = mid ^ x3 ^ lat_i;
    assign carry_o = (mid & x3) | (mid & lat_i) | (x3 & lat_i);
endmodule

// File: rtl/cmp42_row.sv
// A row of WD 4:2 counters, one per bit weight. Four input rows in, two out.
// Carries leaving the top weight are dropped: the sum is kept modulo 2^WD,
// and the final product is known to fit in WD bits.
module cmp42_row #(
    parameter int WD = 16
) (
    input  logic [WD-1:0] in_a,
    input  logic [WD-1:0] in_b,
    input  logic [WD-1:0] in_c,
    input  logic [WD-1:0] in_d,
    output logic [WD-1:0] sum_o,
    output logic [WD-1:0] carry_o
);
    logic [WD-1:0] cy;
    logic [WD-1:0] lat;
    logic          unused_top;

    for (genvar i = 0; i < WD; i++) begin : g_cell
        if (i == 0) begin : g_first
            cnt42 u_cell (
                .x0(in_a[i]), .x1(in_b[i]), .x2(in_c[i]), .x3(in_d[i]),
                .lat_i(1'b0),
                .sum_o(sum_o[i]), .carry_o(cy[i]), .lat_o(lat[i])
            );
        end else begin : g_rest
            cnt42 u_cell (
                .x0(in_a[i]), .x1(in_b[i]), .x2(in_c[i]), .x3(in_d[i]),
                .lat_i(lat[i-1]),
                .sum_o(sum_o[i]), .carry_o(cy[i]), .lat_o(lat[i])
            );
        end
    end

    assign carry_o    = {cy[WD-2:0], 1'b0};
    assign unused_top = cy[WD-1] ^ lat[WD-1];
endmodule

// File: rtl/prefix_adder.sv
// Parallel-prefix carry-propagate adder with log2(WD) combine levels.
// Carry-out is discarded.
module prefix_adder #(
    parameter int WD = 16
) (
    input  logic [WD-1:0] x,
    input  logic [WD-1:0] y,
    output logic [WD-1:0] s
);
    localparam int LV = $clog2(WD);

    always_comb begin : p_prefix
        logic [WD-1:0] gen;
        logic [WD-1:0] prp;
        gen = x & y;
        prp = x ^ y;
        for (int lv = 0; lv < LV; lv++) begin
            // walk downward so lower bits still hold the previous level
            for (int i = WD - 1; i >= (1 << lv); i--) begin
                gen[i] = gen[i] | (prp[i] & gen[i - (1 << lv)]);
                prp[i] = prp[i] & prp[i - (1 << lv)];
            end
        end
        s = (x ^ y) ^ {gen[WD-2:0], 1'b0};
    end
endmodule

// File: rtl/tree_mult.sv
module tree_mult
    import tree_mult_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]   op_a,
    input  logic [W-1:0]   op_b,
    output logic [2*W-1:0] prod
);
    localparam int PW     = 2 * W;
    localparam int LEVELS = $clog2(W) - 1;

    for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
        logic [PW-1:0] r [rows_at(W, l)];

        if (l == 0) begin : g_pp
            // partial-product array, all rows in parallel
            for (genvar i = 0; i < W; i++) begin : g_row
                assign r[i] = PW'(op_a & {W{op_b[i]}}) << i;
            end
        end else begin : g_red
            for (genvar g = 0; g < groups_at(W, l - 1); g++) begin : g_grp
                cmp42_row #(.WD(PW)) u_row (
                    .in_a   (g_lvl[l-1].r[4*g]),
                    .in_b   (g_lvl[l-1].r[4*g+1]),
                    .in_c   (g_lvl[l-1].r[4*g+2]),
                    .in_d   (g_lvl[l-1].r[4*g+3]),
                    .sum_o  (r[2*g]),
                    .carry_o(r[2*g+1])
                );
            end
        end
    end

    prefix_adder #(.WD(PW)) u_cpa (
        .x(g_lvl[LEVELS].r[0]),
        .y(g_lvl[LEVELS].r[1]),
        .s(prod)
    );
endmodule

// File: rtl/tree_mult_chk.sv
module tree_mult_chk #(
    parameter int W = 8
) (
    input logic [W-1:0]   op_a,
    input logic [W-1:0]   op_b,
    input logic [2*W-1:0] prod
);
    localparam int PW = 2 * W;

    always_comb begin
        // R1 / R8
        a_r1_product: assert (prod == PW'(op_a) * PW'(op_b))
            else $error("product mismatch");
        // R2
        a_r2_zero: assert (!((op_a == '0) || (op_b == '0)) || (prod == '0))
            else $error("zero operand gave nonzero product");
        // R3
        a_r3_unit: assert ((op_b != W'(1)) || (prod == PW'(op_a)))
            else $error("multiply by one altered operand");
        // R6
        a_r6_lsb: assert (prod[0] == (op_a[0] & op_b[0]))
            else $error("lsb mismatch");
    end
endmodule

bind tree_mult tree_mult_chk #(.W(W)) u_chk (
    .op_a(op_a),
    .op_b(op_b),
    .prod(prod)
);

// File: tb/tree_mult_test.sv
module tree_mult_test;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;

    logic [7:0]  a8, b8;
    logic [15:0] p8;
    logic [3:0]  a4, b4;
    logic [7:0]  p4;
    logic        cx0, cx1, cx2, cx3, ccin, csum, ccar, clat;

    tree_mult #(.W(8)) uut (.op_a(a8), .op_b(b8), .prod(p8));
    tree_mult #(.W(4)) uut_small (.op_a(a4), .op_b(b4), .prod(p4));
    cnt42 u_cnt (.x0(cx0), .x1(cx1), .x2(cx2), .x3(cx3), .lat_i(ccin),
                 .sum_o(csum), .carry_o(ccar), .lat_o(clat));

    function automatic logic [31:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
        logic [31:0] acc = 0;
        for (int i = 0; i < 16; i++) if (b[i]) acc = acc + (a << i);
        return acc;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // drive after a rising edge, sample at the falling edge (zero latency)
    task automatic apply8(input logic [7:0] a, input logic [7:0] b);
        @(posedge clk);
        a8 = a; b8 = b;
        @(negedge clk);
    endtask

    task automatic apply4(input logic [3:0] a, input logic [3:0] b);
        @(posedge clk);
        a4 = a; b4 = b;
        @(negedge clk);
    endtask

    initial begin
        #2_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] first;
        a8 = 0; b8 = 0; a4 = 0; b4 = 0;
        {cx0, cx1, cx2, cx3, ccin} = '0;
        void'($urandom(32'd20240611));

        // R7: initial state, product present with no clocked stage
        @(negedge clk);
        check("R7 idle zero", p8, 0);

        // R10: 4:2 counter cell, all input combinations
        for (int v = 0; v < 16; v++) begin
            @(posedge clk);
            {cx3, cx2, cx1, cx0} = v[3:0]; ccin = 1'b0;
            @(negedge clk);
            first = {15'd0, clat};
            check("R10 count cin0", csum + 2 * (ccar + clat), $countones(v[3:0]));
            @(posedge clk);
            ccin = 1'b1;
            @(negedge clk);
            check("R10 count cin1", csum + 2 * (ccar + clat), $countones(v[3:0]) + 1);
            check("R10 cout independent of cin", {31'd0, clat}, {16'd0, first});
        end

        // directed corners
        apply8(8'hFF, 8'hFF); check("R4 max", p8, 16'hFE01);
        apply8(8'h00, 8'hA7); check("R2 zero a", p8, 0);
        apply8(8'hC3, 8'h00); check("R2 zero b", p8, 0);
        apply8(8'hB5, 8'h01); check("R3 unit b", p8, 16'h00B5);
        apply8(8'h01, 8'h6E); check("R3 unit a", p8, 16'h006E);
        for (int k = 0; k < 8; k++) begin
            apply8(8'hD9, 8'(1 << k));
            check("R5 power of two", p8, 16'hD9 << k);
        end
        apply8(8'h80, 8'h80); check("R4 top bits", p8, 16'h4000);

        // R9 and R6: random pairs, then swapped
        for (int n = 0; n < 200; n++) begin
            logic [7:0] ra, rb;
            ra = 8'($urandom);
            rb = 8'($urandom);
            apply8(ra, rb);
            first = p8;
            check("R6 lsb", {31'd0, p8[0]}, {31'd0, ra[0] & rb[0]});
            apply8(rb, ra);
            check("R9 commute", p8, first);
        end

        // R1: exhaustive 8x8
        for (int a = 0; a < 256; a++) begin
            for (int b = 0; b < 256; b++) begin
                apply8(8'(a), 8'(b));
                check("R1 exhaustive", p8, ref_mul(a, b));
            end
        end

        // R8: exhaustive 4x4 configuration
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                apply4(4'(a), 4'(b));
                check("R8 4x4", p4, ref_mul(a, b));
            end
        end
        apply4(4'hF, 4'hF); check("R8 4x4 max", p4, 225);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule